// File: doc/BRIEF.md
# Fieldbus Produced-Variable Reply Transmitter

This block answers one master poll on a master/slave fieldbus. A receive path outside the block decodes identification frames and reports each one with a one-cycle valid pulse, its 16-bit variable identifier, and a flag that says whether this node produces that variable. When a matching poll arrives and the block is idle, it waits a fixed turnaround gap. It then shifts out a reply frame on a serial line, with a transmit-enable alongside it.

The reply frame has a fixed layout:
- a 2-byte start pattern;
- one control byte;
- the payload, fetched byte by byte from a produced-data buffer through a synchronous read port;
- a 16-bit CRC over the control byte and the payload;
- a 1-byte end pattern.

A 2-bit rate selector picks one of three bit periods: slow, mid or fast. The selector is sampled only when a poll is accepted. The turnaround gap is a fixed number of bit periods, so it scales with the selected rate. Line coding is handled downstream.

Top module: `prod_reply_tx`

## Requirements
- R1: After reset, `busy_o`, `tx_en_o` and `tx_bit_o` are 0.
- R2: A poll is accepted only when `id_valid_i` and `id_match_i` are both 1 and the block is idle. `busy_o` is 1 from the cycle after acceptance until the reply ends. A poll with `id_match_i` = 0 leaves the block idle.
- R3: The bit period is `DIV_SLOW` clocks for `speed_i` = 00, `DIV_MID` clocks for 01 and 11, and `DIV_FAST` clocks for 10. `tx_en_o` rises exactly `TURN_BITS` bit periods after the accepting clock edge.
- R4: The reply is sent MSB first, one bit per bit period, in this order: `SOF_PAT` high byte, `SOF_PAT` low byte, `CTRL_BYTE`, payload bytes, CRC high byte, CRC low byte, `EOF_PAT`.
- R5: Payload byte k is the value read from buffer address k, for k from 0 up to the payload length minus 1. The buffer returns data one clock after `rd_addr_o` is presented.
- R6: The payload length is `pay_len_i`, sampled at acceptance and clamped to the range 2..124. The frame therefore holds (length + 6) × 8 bits, with `tx_en_o` high for every one of them.
- R7: The CRC uses generator `CRC_POLY`, starts from `CRC_INIT`, processes each byte MSB first with no reflection, and is XORed with `CRC_XOROUT` before it is sent. It covers the control byte and the payload.
- R8: A poll that arrives while `busy_o` is 1 is ignored. The frame in progress and `reply_id_o` stay unchanged.
- R9: `tx_en_o` and `busy_o` fall together one bit period after the last end-pattern bit starts. `tx_bit_o` is 0 whenever `tx_en_o` is 0.
- R10: `reply_id_o` holds the identifier of the most recently accepted poll.
- R11: A change of `speed_i` while busy does not alter the bit period of the reply in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | One-cycle pulse: a decoded identification frame is available |
| id_match_i | input | 1 | The polled variable is produced by this node |
| id_i | input | 16 | Identifier of the polled variable |
| speed_i | input | 2 | Bit-rate selector (00 slow, 01/11 mid, 10 fast) |
| pay_len_i | input | 7 | Requested payload length in bytes |
| rd_addr_o | output | 7 | Produced-buffer read address |
| rd_data_i | input | 8 | Produced-buffer read data, one clock after the address |
| tx_bit_o | output | 1 | Serial reply bit |
| tx_en_o | output | 1 | Transmitter enable, high during the reply frame |
| busy_o | output | 1 | High from acceptance until the end of the reply |
| reply_id_o | output | 16 | Identifier of the accepted poll |

## Verification
The assertions take the following for granted:
- `id_valid_i` arrives as a pulse;
- the buffer answers one clock after the address;
- every divider value is at least 2, so the tick counter wraps.

The stimulus keeps within these limits. It pulses the poll for exactly one cycle and models the buffer as a registered array that does not change during a reply. It overrides the dividers with small values of 2 or more, so every rate, including the reserved code, runs within the cycle budget. Injected polls and rate changes land only in the middle of a frame, where the rules say they must have no effect.

// File: rtl/reply_pkg.sv
package reply_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAP,
    ST_SEND
  } tx_state_e;

  typedef enum logic [2:0] {
    FLD_SOF_HI,
    FLD_SOF_LO,
    FLD_CTRL,
    FLD_DATA,
    FLD_CRC_HI,
    FLD_CRC_LO,
    FLD_EOF
  } field_e;

  function automatic logic [15:0] crc16_byte(input logic [15:0] crc,
                                             input logic [7:0]  data,
                                             input logic [15:0] poly);
    logic [15:0] c;
    logic        fb;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ data[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

endpackage

// File: rtl/rate_tick.sv
module rate_tick #(
  parameter int DIV_SLOW = 4000,
  parameter int DIV_MID  = 125,
  parameter int DIV_FAST = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       run_i,
  input  logic [1:0] speed_i,
  output logic       tick_o
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_MID) ?
                           ((DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST) :
                           ((DIV_MID > DIV_FAST) ? DIV_MID : DIV_FAST);
  localparam int DIV_W = $clog2(DIV_MAX + 1);

  logic [DIV_W-1:0] sel_div, div_q, cnt_q;

  always_comb begin
    unique case (speed_i)
      2'b00:   sel_div = DIV_W'(DIV_SLOW);
      2'b10:   sel_div = DIV_W'(DIV_FAST);
      default: sel_div = DIV_W'(DIV_MID);
    endcase
  end

  assign tick_o = run_i && (cnt_q == div_q - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DIV_W'(DIV_MID);
      cnt_q <= '0;
    end else if (start_i) begin
      // rate is frozen for the whole reply
      div_q <= sel_div;
      cnt_q <= '0;
    end else if (run_i) begin
      if (tick_o) cnt_q <= '0;
      else        cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/crc16_acc.sv
module crc16_acc
  import reply_pkg::*;
#(
  parameter logic [15:0] CRC_POLY   = 16'h1021,
  parameter logic [15:0] CRC_INIT   = 16'hFFFF,
  parameter logic [15:0] CRC_XOROUT = 16'hFFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        upd_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_INIT;
    else if (init_i) crc_q <= crc16_byte(CRC_INIT, data_i, CRC_POLY);
    else if (upd_i)  crc_q <= crc16_byte(crc_q, data_i, CRC_POLY);
  end

  assign crc_o = crc_q ^ CRC_XOROUT;
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import reply_pkg::*;
#(
  parameter int          TURN_BITS = 10,
  parameter int          MIN_LEN   = 2,
  parameter int          MAX_LEN   = 124,
  parameter logic [15:0] SOF_PAT   = 16'hC35A,
  parameter logic [7:0]  CTRL_BYTE = 8'h40,
  parameter logic [7:0]  EOF_PAT   = 8'hF3,
  localparam int         LEN_W     = $clog2(MAX_LEN + 1),
  localparam int         POS_W     = $clog2(MAX_LEN + 7)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             id_valid_i,
  input  logic             id_match_i,
  input  logic [15:0]      id_i,
  input  logic [LEN_W-1:0] pay_len_i,
  input  logic             tick_i,
  input  logic [7:0]       rd_data_i,
  input  logic [15:0]      crc_i,
  output logic             start_o,
  output logic             crc_init_o,
  output logic             crc_upd_o,
  output logic [7:0]       crc_data_o,
  output logic [LEN_W-1:0] rd_addr_o,
  output logic             tx_bit_o,
  output logic             tx_en_o,
  output logic             busy_o,
  output logic [15:0]      reply_id_o
);
  localparam int GAP_W = $clog2(TURN_BITS + 1);

  tx_state_e        state_q;
  logic [GAP_W-1:0] gap_q;
  logic [2:0]       bit_q;
  logic [POS_W-1:0] pos_q, load_pos, last_pos;
  logic [7:0]       shreg_q, load_byte;
  logic [LEN_W-1:0] len_q, eff_len, pay_idx_q;
  logic [15:0]      id_q;
  logic             accept, gap_done, byte_end, frame_end, load_en;
  field_e           load_fld;

  function automatic field_e field_at(input logic [POS_W-1:0] pos,
                                      input logic [LEN_W-1:0] len);
    logic [POS_W-1:0] l;
    l = POS_W'(len);
    if      (pos == POS_W'(0))         return FLD_SOF_HI;
    else if (pos == POS_W'(1))         return FLD_SOF_LO;
    else if (pos == POS_W'(2))         return FLD_CTRL;
    else if (pos < l + POS_W'(3))      return FLD_DATA;
    else if (pos == l + POS_W'(3))     return FLD_CRC_HI;
    else if (pos == l + POS_W'(4))     return FLD_CRC_LO;
    else                               return FLD_EOF;
  endfunction

  always_comb begin
    if (pay_len_i < LEN_W'(MIN_LEN))      eff_len = LEN_W'(MIN_LEN);
    else if (pay_len_i > LEN_W'(MAX_LEN)) eff_len = LEN_W'(MAX_LEN);
    else                                  eff_len = pay_len_i;
  end

  assign accept    = (state_q == ST_IDLE) && id_valid_i && id_match_i;
  assign last_pos  = POS_W'(len_q) + POS_W'(5);
  assign gap_done  = (state_q == ST_GAP) && tick_i && (gap_q == GAP_W'(TURN_BITS - 1));
  assign byte_end  = (state_q == ST_SEND) && tick_i && (bit_q == 3'd7);
  assign frame_end = byte_end && (pos_q == last_pos);
  assign load_en   = gap_done || (byte_end && !frame_end);
  assign load_pos  = gap_done ? '0 : pos_q + POS_W'(1);
  assign load_fld  = field_at(load_pos, len_q);

  always_comb begin
    unique case (load_fld)
      FLD_SOF_HI: load_byte = SOF_PAT[15:8];
      FLD_SOF_LO: load_byte = SOF_PAT[7:0];
      FLD_CTRL:   load_byte = CTRL_BYTE;
      FLD_DATA:   load_byte = rd_data_i;
      FLD_CRC_HI: load_byte = crc_i[15:8];
      FLD_CRC_LO: load_byte = crc_i[7:0];
      default:    load_byte = EOF_PAT;
    endcase
  end

  assign start_o    = accept;
  assign crc_init_o = load_en && (load_fld == FLD_CTRL);
  assign crc_upd_o  = load_en && (load_fld == FLD_DATA);
  assign crc_data_o = load_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      gap_q     <= '0;
      bit_q     <= '0;
      pos_q     <= '0;
      shreg_q   <= '0;
      len_q     <= LEN_W'(MIN_LEN);
      pay_idx_q <= '0;
      id_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q   <= ST_GAP;
          gap_q     <= '0;
          len_q     <= eff_len;
          pay_idx_q <= '0;
          id_q      <= id_i;
        end
        ST_GAP: if (tick_i) begin
          if (gap_done) state_q <= ST_SEND;
          else          gap_q   <= gap_q + GAP_W'(1);
        end
        ST_SEND: if (frame_end) begin
          state_q <= ST_IDLE;
        end else if (tick_i && !byte_end) begin
          bit_q   <= bit_q + 3'd1;
          shreg_q <= {shreg_q[6:0], 1'b0};
        end
        default: state_q <= ST_IDLE;
      endcase
      if (load_en) begin
        shreg_q <= load_byte;
        pos_q   <= load_pos;
        bit_q   <= '0;
        if (load_fld == FLD_DATA) pay_idx_q <= pay_idx_q + LEN_W'(1);
      end
    end
  end

  assign rd_addr_o  = pay_idx_q;
  assign tx_en_o    = (state_q == ST_SEND);
  assign tx_bit_o   = tx_en_o && shreg_q[7];
  assign busy_o     = (state_q != ST_IDLE);
  assign reply_id_o = id_q;
endmodule

// File: rtl/prod_reply_tx.sv
module prod_reply_tx #(
  parameter int          DIV_SLOW   = 4000,
  parameter int          DIV_MID    = 125,
  parameter int          DIV_FAST   = 50,
  parameter int          TURN_BITS  = 10,
  parameter int          MIN_LEN    = 2,
  parameter int          MAX_LEN    = 124,
  parameter logic [15:0] SOF_PAT    = 16'hC35A,
  parameter logic [7:0]  CTRL_BYTE  = 8'h40,
  parameter logic [7:0]  EOF_PAT    = 8'hF3,
  parameter logic [15:0] CRC_POLY   = 16'h1021,
  parameter logic [15:0] CRC_INIT   = 16'hFFFF,
  parameter logic [15:0] CRC_XOROUT = 16'hFFFF,
  localparam int         LEN_W      = $clog2(MAX_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             id_valid_i,
  input  logic             id_match_i,
  input  logic [15:0]      id_i,
  input  logic [1:0]       speed_i,
  input  logic [LEN_W-1:0] pay_len_i,
  output logic [LEN_W-1:0] rd_addr_o,
  input  logic [7:0]       rd_data_i,
  output logic             tx_bit_o,
  output logic             tx_en_o,
  output logic             busy_o,
  output logic [15:0]      reply_id_o
);
  logic        bit_tick, start, crc_init, crc_upd;
  logic [7:0]  crc_data;
  logic [15:0] crc_val;

  rate_tick #(
    .DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID), .DIV_FAST(DIV_FAST)
  ) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .run_i(busy_o),
    .speed_i(speed_i), .tick_o(bit_tick)
  );

  crc16_acc #(
    .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT), .CRC_XOROUT(CRC_XOROUT)
  ) u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(crc_init), .upd_i(crc_upd),
    .data_i(crc_data), .crc_o(crc_val)
  );

  frame_seq #(
    .TURN_BITS(TURN_BITS), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN),
    .SOF_PAT(SOF_PAT), .CTRL_BYTE(CTRL_BYTE), .EOF_PAT(EOF_PAT)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .id_valid_i(id_valid_i),
    .id_match_i(id_match_i), .id_i(id_i), .pay_len_i(pay_len_i),
    .tick_i(bit_tick), .rd_data_i(rd_data_i), .crc_i(crc_val),
    .start_o(start), .crc_init_o(crc_init), .crc_upd_o(crc_upd),
    .crc_data_o(crc_data), .rd_addr_o(rd_addr_o), .tx_bit_o(tx_bit_o),
    .tx_en_o(tx_en_o), .busy_o(busy_o), .reply_id_o(reply_id_o)
  );
endmodule

// File: rtl/reply_chk.sv
module reply_chk #(
  parameter int MAX_LEN = 124,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             id_valid_i,
  input logic             id_match_i,
  input logic             bit_tick,
  input logic [LEN_W-1:0] rd_addr_o,
  input logic             tx_bit_o,
  input logic             tx_en_o,
  input logic             busy_o,
  input logic [15:0]      reply_id_o
);
  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && id_valid_i && id_match_i |=> busy_o && !tx_en_o);

  p_no_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !(id_valid_i && id_match_i) |=> !busy_o);

  p_bit_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o && $past(tx_en_o) && !$past(bit_tick) |-> $stable(tx_bit_o));

  p_addr_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> rd_addr_o <= LEN_W'(MAX_LEN));

  p_id_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(reply_id_o));

  p_en_in_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> busy_o);

  p_quiet_line_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_o |-> !tx_bit_o);

  p_end_on_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_en_o) |-> $past(bit_tick) && !busy_o);
endmodule

bind prod_reply_tx reply_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .id_valid_i(id_valid_i),
  .id_match_i(id_match_i), .bit_tick(bit_tick), .rd_addr_o(rd_addr_o),
  .tx_bit_o(tx_bit_o), .tx_en_o(tx_en_o), .busy_o(busy_o),
  .reply_id_o(reply_id_o)
);

// File: tb/prod_reply_tx_test.sv
`timescale 1ns/1ps
module prod_reply_tx_test;
  localparam int          D_SLOW = 7, D_MID = 4, D_FAST = 2, TURN = 10;
  localparam int          MAXL = 124, LW = 7;
  localparam logic [15:0] SOF = 16'hC35A, POLY = 16'h1021, INIT = 16'hFFFF, XOUT = 16'hFFFF;
  localparam logic [7:0]  CTRL = 8'h40, EOF = 8'hF3;

  // {speed, requested len, expected len, seed}
  localparam int NV = 7;
  localparam logic [23:0] VEC [NV] = '{
    {2'b00, 7'd2,   7'd2,   8'h11},
    {2'b01, 7'd8,   7'd8,   8'h3C},
    {2'b10, 7'd124, 7'd124, 8'hA7},
    {2'b11, 7'd5,   7'd5,   8'h62},
    {2'b01, 7'd0,   7'd2,   8'h9E},
    {2'b10, 7'd127, 7'd124, 8'h05},
    {2'b00, 7'd17,  7'd17,  8'hD4}
  };

  logic clk = 0, rst_n = 0;
  logic id_valid = 0, id_match = 0;
  logic [15:0] id = '0;
  logic [1:0] speed = 2'b01;
  logic [LW-1:0] pay_len = '0, rd_addr;
  logic [7:0] rd_data;
  logic tx_bit, tx_en, busy;
  logic [15:0] reply_id;
  logic [7:0] mem [0:127];
  int checks = 0, failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) rd_data <= mem[rd_addr];

  prod_reply_tx #(
    .DIV_SLOW(D_SLOW), .DIV_MID(D_MID), .DIV_FAST(D_FAST), .TURN_BITS(TURN),
    .SOF_PAT(SOF), .CTRL_BYTE(CTRL), .EOF_PAT(EOF),
    .CRC_POLY(POLY), .CRC_INIT(INIT), .CRC_XOROUT(XOUT)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .id_valid_i(id_valid), .id_match_i(id_match),
    .id_i(id), .speed_i(speed), .pay_len_i(pay_len), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .tx_bit_o(tx_bit), .tx_en_o(tx_en), .busy_o(busy),
    .reply_id_o(reply_id)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) r = (r[15] ^ d[i]) ? ({r[14:0], 1'b0} ^ POLY) : {r[14:0], 1'b0};
    return r;
  endfunction

  function automatic int div_of(input logic [1:0] s);
    return (s == 2'b00) ? D_SLOW : (s == 2'b10) ? D_FAST : D_MID;
  endfunction

  task automatic run_reply(input logic [1:0] spd, input int len_req, input int len_exp,
                           input logic [7:0] seed, input logic [15:0] rid, input bit inject);
    int d, gap, nb, low_en, bad_pay;
    logic [7:0] got [0:131];
    logic [15:0] crc;
    d = div_of(spd);
    nb = len_exp + 6;
    for (int i = 0; i < 128; i++) mem[i] = seed ^ 8'(i * 37) ^ 8'(i >> 2);
    @(negedge clk);
    speed = spd; pay_len = LW'(len_req); id = rid; id_valid = 1; id_match = 1;
    @(negedge clk);
    id_valid = 0;
    chk("R2 busy after accept", 32'(busy), 1);
    gap = 0;
    while (!tx_en && gap < 100000) begin
      gap++;
      @(negedge clk);
    end
    chk("R3 turnaround cycles", gap, TURN * d);
    low_en = 0;
    for (int k = 0; k < nb * 8; k++) begin
      if (!tx_en) low_en++;
      got[k / 8][7 - (k % 8)] = tx_bit;
      for (int j = 0; j < d; j++) begin
        if (inject && k == 20 && j == 0) begin
          id_valid = 1; id = ~rid; speed = ~spd; pay_len = 7'd3;
        end
        @(negedge clk);
        id_valid = 0;
      end
    end
    chk("R6 tx_en held for full frame", low_en, 0);
    chk("R9 tx_en low after frame", 32'(tx_en), 0);
    chk("R9 busy low after frame", 32'(busy), 0);
    chk("R4 start pattern", {got[0], got[1]}, SOF);
    chk("R4 control byte", got[2], CTRL);
    bad_pay = 0;
    crc = crc_step(INIT, CTRL);
    for (int i = 0; i < len_exp; i++) begin
      if (got[3 + i] !== mem[i]) bad_pay++;
      crc = crc_step(crc, mem[i]);
    end
    chk("R5 payload mismatches", bad_pay, 0);
    chk("R7 crc", {got[3 + len_exp], got[4 + len_exp]}, crc ^ XOUT);
    chk("R4 end pattern", got[5 + len_exp], EOF);
    chk(inject ? "R8 reply_id kept" : "R10 reply_id", reply_id, rid);
    speed = spd;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++;
        checks++;
        $display("FAIL watchdog act=%0d exp<150000", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 0);
    chk("R1 tx_en in reset", 32'(tx_en), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 tx_bit after reset", 32'(tx_bit), 0);
    chk("R1 busy after reset", 32'(busy), 0);

    for (int v = 0; v < NV; v++)
      run_reply(VEC[v][23:22], int'(VEC[v][21:15]), int'(VEC[v][14:8]), VEC[v][7:0],
                16'h1000 + 16'(v), 1'b0);

    // R2: poll for a variable not produced here
    @(negedge clk);
    id_valid = 1; id_match = 0; id = 16'hBEEF;
    @(negedge clk);
    id_valid = 0;
    repeat (3) @(negedge clk);
    chk("R2 no match stays idle", 32'(busy), 0);
    chk("R10 reply_id after no-match", reply_id, 16'h1006);

    // R8/R11: poll and speed change mid-frame ignored
    run_reply(2'b01, 10, 10, 8'h77, 16'h2ABC, 1'b1);
    run_reply(2'b10, 3, 3, 8'h48, 16'h0F0F, 1'b1);

    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule